// File: doc/BRIEF.md
# System Clock Source Sequencer

This block decides where the system clock comes from and keeps the switch between sources safe. There are three sources. In locked mode the VCO runs locked to the oscillator. In free-run mode the VCO runs on its own at its base frequency, with the oscillator disconnected from the loop. In divided mode the VCO is bypassed and the oscillator, divided by P times K (P fixed at 1, K either 1 or 2), drives the system. Software writes one control word. That word holds three persistent bits (VCO bypass, oscillator disconnect, oscillator power-down) and three one-shot bits (restart oscillator detection, restart lock detection, clear the loss-of-lock flag).

The sequencer checks each write against the current state. It rejects any step taken out of order. The restore order is fixed: power up the oscillator, restart oscillator detection and wait for the running flag, reconnect, restart lock detection and wait for the lock flag, and only then leave bypass. A disconnect made without bypass already set is accepted, but it raises a sticky loss-of-lock flag meant for a non-maskable interrupt. The clock select only changes while the outgoing clock is low. The analog parts are outside the block. They answer the restart pulses through the running and lock status inputs.

Top module: `clksrc_seq`

## Requirements
- R1: After reset, bypass, disconnect and power-down are 0, the select is 0, the running and lock flags are 1, and the loss-of-lock, error and stall outputs are 0.
- R2: Control word fields: bit 0 bypass, bit 1 disconnect, bit 2 power-down, bit 3 restart oscillator detection, bit 4 restart lock detection, bit 5 clear loss-of-lock. The target select is 0 (locked) when bypass is 0, 1 (divided) when bypass is 1 and disconnect is 0, and 2 (free-run) when both are 1.
- R3: The select moves to the target only at a clock edge where the outgoing clock level is sampled low. The outgoing clock is the oscillator level in divided mode and the VCO level otherwise. The earliest move is one cycle after the control bits change.
- R4: A write that raises disconnect while bypass is currently 0 sets the loss-of-lock flag. The flag holds until a write with bit 5 set, and a new loss of lock in that same write takes priority.
- R5: Raising power-down is accepted only while bypass and disconnect are both currently 1. Otherwise power-down stays 0 and the write counts as rejected.
- R6: Clearing bypass is rejected, and bypass stays 1, while disconnect is 1 or the lock flag is 0.
- R7: Clearing disconnect is rejected, and disconnect stays 1, while power-down is 1.
- R8: The error output shows whether the most recent write had any rejected field. A write with no rejection clears it.
- R9: A write with bit 3 clears the running flag at the same edge and drives a one-cycle restart pulse. The flag sets again only one cycle after the running input rises after that restart. An accepted power-down also clears the flag.
- R10: A write with bit 4 clears the lock flag at the same edge and drives a one-cycle restart pulse. The flag sets one cycle after the lock input rises after that restart. An accepted disconnect rise also clears the flag.
- R11: A fall on the running input or the lock input clears the matching flag.
- R12: The stall output is 1 exactly when the select is 1 (divided) and the running flag is 0, because divided mode has no fallback clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 6 | Control word (fields per R2) |
| osc_run_i | input | 1 | Oscillator running indication from analog |
| pll_lock_i | input | 1 | Lock indication from analog |
| vco_lvl_i | input | 1 | Sampled level of the VCO-derived clock |
| osc_lvl_i | input | 1 | Sampled level of the oscillator-derived clock |
| byp_o | output | 1 | VCO bypass bit |
| disc_o | output | 1 | Oscillator disconnect bit |
| pd_o | output | 1 | Oscillator power-down bit |
| osc_rst_o | output | 1 | Oscillator detection restart pulse |
| lock_rst_o | output | 1 | Lock detection restart pulse |
| osc_ok_o | output | 1 | Oscillator running flag |
| lock_ok_o | output | 1 | Lock flag |
| nmi_o | output | 1 | Sticky loss-of-lock flag |
| err_o | output | 1 | Last write had a rejected field |
| sel_o | output | 2 | Glitch-free clock mux select |
| stall_o | output | 1 | Divided mode with no running oscillator |

## Verification
The hardest state to reach is the end of a full restore from free-run mode back to locked mode. Getting there takes every handshake in order, with the analog stub answering each restart after a delay. The bench walks that path and tries each out-of-order step on the way: clearing disconnect while powered down, and leaving bypass while still disconnected or before lock returns. The oscillator and VCO levels are held high on purpose for some cycles after a source change, so the wait inside the mux is exercised. The bench also makes the false loss-of-lock case, and an oscillator failure in divided mode.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
  localparam int CTL_W = 6;
  localparam int SEL_W = 2;
  localparam int F_BYP  = 0;
  localparam int F_DISC = 1;
  localparam int F_PD   = 2;
  localparam int F_ORST = 3;
  localparam int F_LRST = 4;
  localparam int F_NCLR = 5;
  typedef enum logic [SEL_W-1:0] {
    SRC_PLL   = 2'd0,
    SRC_PRESC = 2'd1,
    SRC_VBASE = 2'd2
  } src_e;
endpackage

// File: rtl/clksrc_ctrl.sv
module clksrc_ctrl
  import clksrc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             lock_ok,
  output logic             byp_q,
  output logic             disc_q,
  output logic             pd_q,
  output logic             nmi_q,
  output logic             err_q,
  output logic             orst_q,
  output logic             lrst_q,
  output logic             disc_rise,
  output logic             pd_rise
);
  logic byp_nx, disc_nx, pd_nx, rej_byp, rej_disc, rej_pd, false_lol;

  always_comb begin
    rej_byp  = byp_q && !wr_data[F_BYP] && (disc_q || !lock_ok);
    rej_disc = disc_q && !wr_data[F_DISC] && pd_q;
    rej_pd   = !pd_q && wr_data[F_PD] && !(byp_q && disc_q);
    byp_nx   = rej_byp  ? 1'b1 : wr_data[F_BYP];
    disc_nx  = rej_disc ? 1'b1 : wr_data[F_DISC];
    pd_nx    = rej_pd   ? 1'b0 : wr_data[F_PD];
    disc_rise = wr_en && !disc_q && disc_nx;
    pd_rise   = wr_en && !pd_q && pd_nx;
    false_lol = disc_rise && !byp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_q  <= 1'b0;
      disc_q <= 1'b0;
      pd_q   <= 1'b0;
      nmi_q  <= 1'b0;
      err_q  <= 1'b0;
      orst_q <= 1'b0;
      lrst_q <= 1'b0;
    end else begin
      orst_q <= wr_en && wr_data[F_ORST];
      lrst_q <= wr_en && wr_data[F_LRST];
      if (wr_en) begin
        byp_q  <= byp_nx;
        disc_q <= disc_nx;
        pd_q   <= pd_nx;
        err_q  <= rej_byp || rej_disc || rej_pd;
        if (false_lol)
          nmi_q <= 1'b1;
        else if (wr_data[F_NCLR])
          nmi_q <= 1'b0;
      end
    end
  end

  a_r5_pd_only_in_base: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_q) |-> $past(byp_q && disc_q));
  a_r6_bypass_hold: assert property (@(posedge clk) disable iff (rst)
    $fell(byp_q) |-> $past(!disc_q && lock_ok));
  a_r7_disc_hold: assert property (@(posedge clk) disable iff (rst)
    $fell(disc_q) |-> $past(!pd_q));
  a_r4_nmi_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_q) |-> ($rose(disc_q) && $past(!byp_q)));
endmodule

// File: rtl/clksrc_flag.sv
module clksrc_flag (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic kill,
  input  logic raw,
  output logic flag_q
);
  logic wait_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b1;
      wait_q <= 1'b0;
      prev_q <= 1'b1;
    end else begin
      prev_q <= raw;
      if (restart || kill) begin
        flag_q <= 1'b0;
        wait_q <= restart;
      end else if (prev_q && !raw) begin
        flag_q <= 1'b0;
      end else if (wait_q && raw && !prev_q) begin
        flag_q <= 1'b1;
        wait_q <= 1'b0;
      end
    end
  end

  a_r9_set_after_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(raw));
  a_r11_clear_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(restart || kill || !raw));
endmodule

// File: rtl/clksrc_gmux.sv
module clksrc_gmux
  import clksrc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             byp,
  input  logic             disc,
  input  logic             vco_lvl,
  input  logic             osc_lvl,
  output logic [SEL_W-1:0] sel_q
);
  src_e tgt;
  logic out_lvl;

  always_comb begin
    if (!byp)      tgt = SRC_PLL;
    else if (disc) tgt = SRC_VBASE;
    else           tgt = SRC_PRESC;
    out_lvl = (sel_q == SRC_PRESC) ? osc_lvl : vco_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst)
      sel_q <= SRC_PLL;
    else if ((sel_q != tgt) && !out_lvl)
      sel_q <= tgt;
  end

  a_r3_switch_when_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_q) |-> $past(($past(sel_q) == SRC_PRESC) ? !osc_lvl : !vco_lvl));
  a_r2_legal_select: assert property (@(posedge clk) disable iff (rst)
    sel_q != 2'd3);
endmodule

// File: rtl/clksrc_seq.sv
module clksrc_seq
  import clksrc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             osc_run_i,
  input  logic             pll_lock_i,
  input  logic             vco_lvl_i,
  input  logic             osc_lvl_i,
  output logic             byp_o,
  output logic             disc_o,
  output logic             pd_o,
  output logic             osc_rst_o,
  output logic             lock_rst_o,
  output logic             osc_ok_o,
  output logic             lock_ok_o,
  output logic             nmi_o,
  output logic             err_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             stall_o
);
  logic disc_rise, pd_rise, orst_now, lrst_now;

  assign orst_now = wr_en && wr_data[F_ORST];
  assign lrst_now = wr_en && wr_data[F_LRST];

  clksrc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .lock_ok(lock_ok_o), .byp_q(byp_o), .disc_q(disc_o), .pd_q(pd_o),
    .nmi_q(nmi_o), .err_q(err_o), .orst_q(osc_rst_o), .lrst_q(lock_rst_o),
    .disc_rise(disc_rise), .pd_rise(pd_rise)
  );

  clksrc_flag u_oscf (
    .clk(clk), .rst(rst), .restart(orst_now), .kill(pd_rise),
    .raw(osc_run_i), .flag_q(osc_ok_o)
  );

  clksrc_flag u_lockf (
    .clk(clk), .rst(rst), .restart(lrst_now), .kill(disc_rise),
    .raw(pll_lock_i), .flag_q(lock_ok_o)
  );

  clksrc_gmux u_gmux (
    .clk(clk), .rst(rst), .byp(byp_o), .disc(disc_o),
    .vco_lvl(vco_lvl_i), .osc_lvl(osc_lvl_i), .sel_q(sel_o)
  );

  assign stall_o = (sel_o == SRC_PRESC) && !osc_ok_o;

  a_r10_lock_restart_clears: assert property (@(posedge clk) disable iff (rst)
    lrst_now |=> (!lock_ok_o && lock_rst_o));
  a_r9_osc_restart_clears: assert property (@(posedge clk) disable iff (rst)
    orst_now |=> (!osc_ok_o && osc_rst_o));
endmodule

// File: tb/clksrc_seq_tb.sv
module clksrc_seq_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0;
  logic [5:0] wr_data = '0;
  logic osc_run, pll_lock, vco_lvl = 1'b0, osc_lvl = 1'b0;
  logic byp_o, disc_o, pd_o, osc_rst_o, lock_rst_o, osc_ok_o, lock_ok_o, nmi_o, err_o, stall_o;
  logic [1:0] sel_o;
  int compared = 0, mismatched = 0, cyc = 0;
  bit vco_hold = 0, osc_hold = 0, osc_fail = 0;
  localparam int OSC_DLY = 6, LOCK_DLY = 9;

  clksrc_seq u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .osc_run_i(osc_run), .pll_lock_i(pll_lock), .vco_lvl_i(vco_lvl), .osc_lvl_i(osc_lvl),
    .byp_o(byp_o), .disc_o(disc_o), .pd_o(pd_o), .osc_rst_o(osc_rst_o),
    .lock_rst_o(lock_rst_o), .osc_ok_o(osc_ok_o), .lock_ok_o(lock_ok_o),
    .nmi_o(nmi_o), .err_o(err_o), .sel_o(sel_o), .stall_o(stall_o)
  );

  always #5 clk = ~clk;

  // analog stub
  int ocnt, lcnt;
  always @(posedge clk) begin
    if (rst) begin
      osc_run <= 1; pll_lock <= 1; ocnt <= 0; lcnt <= 0;
    end else begin
      if (pd_o || osc_fail) begin osc_run <= 0; ocnt <= 0; end
      else if (osc_rst_o) begin osc_run <= 0; ocnt <= OSC_DLY; end
      else if (ocnt > 0) begin ocnt <= ocnt - 1; if (ocnt == 1) osc_run <= 1; end
      if (disc_o) begin pll_lock <= 0; lcnt <= 0; end
      else if (lock_rst_o) begin pll_lock <= 0; lcnt <= LOCK_DLY; end
      else if (lcnt > 0) begin lcnt <= lcnt - 1; if (lcnt == 1 && osc_run) pll_lock <= 1; end
    end
  end

  // clock level patterns
  int lv;
  always @(negedge clk) begin
    lv <= lv + 1;
    vco_lvl <= vco_hold ? 1'b1 : lv[0];
    osc_lvl <= osc_hold ? 1'b1 : (lv % 3 == 0);
  end

  // behavioural reference model
  bit m_byp, m_disc, m_pd, m_nmi, m_err, m_orp, m_lrp;
  bit m_of, m_ow, m_op, m_lf, m_lw, m_lp;
  int m_sel;
  always @(posedge clk) begin
    if (rst) begin
      m_byp = 0; m_disc = 0; m_pd = 0; m_nmi = 0; m_err = 0; m_orp = 0; m_lrp = 0;
      m_of = 1; m_ow = 0; m_op = 1; m_lf = 1; m_lw = 0; m_lp = 1; m_sel = 0;
    end else begin
      bit nb, nd, np, rej, orst, lrst, drise, prise;
      int tgt, lvl;
      tgt = !m_byp ? 0 : (m_disc ? 2 : 1);
      lvl = (m_sel == 1) ? osc_lvl : vco_lvl;
      orst = wr_en && wr_data[3];
      lrst = wr_en && wr_data[4];
      nb = m_byp; nd = m_disc; np = m_pd; drise = 0; prise = 0; rej = 0;
      if (wr_en) begin
        nb = wr_data[0]; nd = wr_data[1]; np = wr_data[2];
        if (m_byp && !nb && (m_disc || !m_lf)) begin nb = 1; rej = 1; end
        if (m_disc && !nd && m_pd) begin nd = 1; rej = 1; end
        if (!m_pd && np && !(m_byp && m_disc)) begin np = 0; rej = 1; end
        drise = !m_disc && nd;
        prise = !m_pd && np;
        if (drise && !m_byp) m_nmi = 1;
        else if (wr_data[5]) m_nmi = 0;
        m_err = rej;
      end
      if (orst || prise) begin m_of = 0; m_ow = orst; end
      else if (m_op && !osc_run) m_of = 0;
      else if (m_ow && osc_run && !m_op) begin m_of = 1; m_ow = 0; end
      m_op = osc_run;
      if (lrst || drise) begin m_lf = 0; m_lw = lrst; end
      else if (m_lp && !pll_lock) m_lf = 0;
      else if (m_lw && pll_lock && !m_lp) begin m_lf = 1; m_lw = 0; end
      m_lp = pll_lock;
      if (m_sel != tgt && lvl == 0) m_sel = tgt;
      m_byp = nb; m_disc = nd; m_pd = np; m_orp = orst; m_lrp = lrst;
    end
  end

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #2;
    chk("R2 R6 bypass", byp_o, m_byp);
    chk("R7 disconnect", disc_o, m_disc);
    chk("R5 powerdown", pd_o, m_pd);
    chk("R4 loss-of-lock", nmi_o, m_nmi);
    chk("R8 error", err_o, m_err);
    chk("R9 osc pulse", osc_rst_o, m_orp);
    chk("R10 lock pulse", lock_rst_o, m_lrp);
    chk("R9 R11 osc flag", osc_ok_o, m_of);
    chk("R10 R11 lock flag", lock_ok_o, m_lf);
    chk("R3 select", sel_o, m_sel);
    chk("R12 stall", stall_o, (m_sel == 1 && !m_of));
  end

  task automatic wr(logic [5:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset byp", byp_o, 0); chk("R1 reset sel", sel_o, 0);
    chk("R1 reset osc", osc_ok_o, 1); chk("R1 reset lock", lock_ok_o, 1);
    chk("R1 reset nmi", nmi_o, 0);
    // R2 R3: to divided mode with VCO level held high
    vco_hold = 1;
    wr(6'b000001);
    idle(4);
    chk("R3 waits while outgoing high", sel_o, 0);
    vco_hold = 0;
    idle(4);
    chk("R2 divided select", sel_o, 1);
    // to free-run; osc held high
    osc_hold = 1;
    wr(6'b000011);
    idle(3);
    chk("R3 held in divided", sel_o, 1);
    osc_hold = 0;
    idle(4);
    chk("R2 free-run select", sel_o, 2);
    chk("R10 lock cleared on disconnect", lock_ok_o, 0);
    chk("R4 no nmi with bypass", nmi_o, 0);
    // R5 power down accepted
    wr(6'b000111);
    idle(2);
    chk("R5 pd accepted", pd_o, 1);
    // R7 reject clearing disc while pd
    wr(6'b000101);
    chk("R7 disc kept", disc_o, 1);
    chk("R8 err set", err_o, 1);
    // R6 reject clearing bypass while disconnected
    wr(6'b000010);
    chk("R6 bypass kept", byp_o, 1);
    // restore
    wr(6'b000011);
    chk("R8 err cleared", err_o, 0);
    wr(6'b001011);
    idle(OSC_DLY + 4);
    chk("R9 running after restart", osc_ok_o, 1);
    wr(6'b000001);
    idle(4);
    wr(6'b010001);
    wr(6'b000000);
    chk("R6 bypass kept before lock", byp_o, 1);
    idle(LOCK_DLY + 4);
    chk("R10 locked", lock_ok_o, 1);
    wr(6'b000000);
    idle(4);
    chk("R6 back to locked", sel_o, 0);
    // R5 reject pd outside free-run
    wr(6'b000100);
    chk("R5 pd rejected", pd_o, 0);
    // R4 false loss of lock
    wr(6'b000010);
    chk("R4 nmi set", nmi_o, 1);
    idle(3);
    wr(6'b000000);
    chk("R4 nmi sticky", nmi_o, 1);
    wr(6'b100000);
    chk("R4 nmi cleared", nmi_o, 0);
    wr(6'b010000);
    idle(LOCK_DLY + 4);
    // R12 oscillator failure in divided mode
    wr(6'b000001);
    idle(6);
    osc_fail = 1;
    idle(3);
    chk("R12 stall on osc failure", stall_o, 1);
    chk("R11 osc flag fell", osc_ok_o, 0);
    osc_fail = 0;
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule